// File: doc/BRIEF.md
# Seven-Slot Serial Display Link Transmitter

This block turns a wide parallel pixel word into a set of serial lanes for a flat-panel display link. It runs entirely in a bit-rate clock domain that is seven times the pixel rate. The pixel clock is an ordinary input sampled in that domain. Once per pixel period one full word is captured on the selected pixel-clock edge. At the next period boundary the word is split into seven-bit groups, one group per lane, and each lane sends its group one bit per bit-clock cycle. A forwarded clock lane sends a fixed seven-slot pattern alongside the data, so a receiver can find the period boundary.

The lane count is a parameter. Four lanes carry a 28-bit word: three 8-bit colours, horizontal sync, vertical sync, data enable and a spare. Three lanes carry a 21-bit word with 6-bit colours and the three sync and enable lines. The block treats the word as opaque, so where each field sits inside it is the integrator's choice.

Each output has an enable flag that stands in for the tristate control of a differential driver. An active-low power-down input drops every enable at once. After reset, or after power-down is released, the enables stay low until a fresh word has been captured and its first slot begins.

Top module: `tx7_link`

## Requirements
- R1: With `edge_sel` high the word is captured at the rising edge of `pix_clk`; with `edge_sel` low it is captured at the falling edge. Both edges are observed in the `clk_ser` domain.
- R2: An internal slot counter steps 0,1,…,6,0 on every `clk_ser` cycle, starting from 0 at reset. While the counter is at slot s, `lane_bit[k]` carries bit 7k+s of the word being sent.
- R3: A captured word starts on the cycle after the counter wraps from 6 to 0, and it is held across all seven slots of that period. Input changes made after the capture have no effect until the next period boundary.
- R4: During slots 0 to 6, `fclk_bit` follows the pattern 1,1,0,0,0,1,1. It is therefore high in slot 0, which marks the reference edge.
- R5: `NUM_LANES` = 4 gives a 28-bit word on four lanes. `NUM_LANES` = 3 gives a 21-bit word on three lanes. Slot timing is the same in both.
- R6: While `pwr_dn_n` is low, every `lane_oe` bit and `fclk_oe` are 0, and every serial output is driven to 0, in the same cycle.
- R7: After reset, or after `pwr_dn_n` rises, the enables stay 0 until the first wrap that follows a capture made while powered up.
- R8: During and right after reset, all enables and serial outputs are 0.
- R9: A word presented while `pwr_dn_n` is low never appears on the lanes. The first word sent after release is the first one captured after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Bit-rate clock, seven cycles per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled in the `clk_ser` domain |
| edge_sel | input | 1 | Capture edge: 1 = rising, 0 = falling |
| pwr_dn_n | input | 1 | Active-low power-down |
| pix_data | input | 7*NUM_LANES | Parallel pixel word |
| lane_bit | output | NUM_LANES | Serial data bit per lane |
| lane_oe | output | NUM_LANES | Driver enable per data lane |
| fclk_bit | output | 1 | Forwarded clock lane bit |
| fclk_oe | output | 1 | Driver enable of the clock lane |

## Verification
Corruption of the slot counter shows up within one pixel period. The forwarded clock loses its 1,1,0,0,0,1,1 shape, and every lane bit moves to the wrong slot. A wrong capture edge or a load at the wrong time shows on the first period after the faulty capture: the lanes carry the half-period word the wrong edge would have sampled, or a mix of two words. A faulty enable state shows either as drivers turning on one period early after release, when they would still carry a word captured during power-down, or as drivers that fail to turn off in the same cycle `pwr_dn_n` falls.

// File: rtl/tx7_pkg.sv
package tx7_pkg;
  localparam int SLOTS = 7;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  // forwarded clock level per slot, bit s = slot s
  localparam logic [SLOTS-1:0] FCLK_PAT = 7'b1100011;

  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + 1'b1;
  endfunction

  function automatic logic fclk_level(input logic [SLOT_W-1:0] s);
    return (s <= LAST_SLOT) ? FCLK_PAT[s] : 1'b0;
  endfunction

  function automatic logic strobe_hit(input logic rise_mode, input logic cur, input logic prev);
    return rise_mode ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/tx7_slot_seq.sv
module tx7_slot_seq
  import tx7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot_after(slot);
  end

  assign wrap = (slot == LAST_SLOT);

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST_SLOT) else $error("slot out of range");
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != LAST_SLOT) |=> (slot == $past(slot) + SLOT_W'(1))) else $error("slot step");
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (slot == '0)) else $error("slot wrap");
endmodule

// File: rtl/tx7_capture.sv
module tx7_capture
  import tx7_pkg::*;
#(
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              edge_sel,
  input  logic              live,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] cap_word,
  output logic              cap_valid
);
  logic pix_q;
  logic cap_fire;

  assign cap_fire = live & strobe_hit(edge_sel, pix_clk, pix_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q     <= 1'b0;
      cap_word  <= '0;
      cap_valid <= 1'b0;
    end else begin
      pix_q <= pix_clk;
      if (!live) begin
        cap_valid <= 1'b0;
      end else if (cap_fire) begin
        cap_word  <= din;
        cap_valid <= 1'b1;
      end
    end
  end

  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(cap_word)) else $error("captured word moved without strobe");
  p_pd_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !cap_valid) else $error("capture valid during power-down");
endmodule

// File: rtl/tx7_lane_ser.sv
module tx7_lane_ser
  import tx7_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int DATA_W = NUM_LANES * SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_W-1:0]    word,
  output logic [NUM_LANES-1:0] bits
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [SLOTS-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sh <= '0;
      else if (load) sh <= word[g*SLOTS +: SLOTS];
      else           sh <= {1'b0, sh[SLOTS-1:1]};
    end
    assign bits[g] = sh[0];
  end
endmodule

// File: rtl/tx7_link.sv
module tx7_link
  import tx7_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int DATA_W = NUM_LANES * SLOTS
) (
  input  logic                 clk_ser,
  input  logic                 rst_n,
  input  logic                 pix_clk,
  input  logic                 edge_sel,
  input  logic                 pwr_dn_n,
  input  logic [DATA_W-1:0]    pix_data,
  output logic [NUM_LANES-1:0] lane_bit,
  output logic [NUM_LANES-1:0] lane_oe,
  output logic                 fclk_bit,
  output logic                 fclk_oe
);
  logic [SLOT_W-1:0]    slot;
  logic                 wrap;
  logic [DATA_W-1:0]    cap_word;
  logic                 cap_valid;
  logic [NUM_LANES-1:0] ser_bits;
  logic                 en_q;
  logic                 drive;

  tx7_slot_seq u_seq (
    .clk  (clk_ser),
    .rst_n(rst_n),
    .slot (slot),
    .wrap (wrap)
  );

  tx7_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk_ser),
    .rst_n    (rst_n),
    .pix_clk  (pix_clk),
    .edge_sel (edge_sel),
    .live     (pwr_dn_n),
    .din      (pix_data),
    .cap_word (cap_word),
    .cap_valid(cap_valid)
  );

  tx7_lane_ser #(.NUM_LANES(NUM_LANES)) u_ser (
    .clk  (clk_ser),
    .rst_n(rst_n),
    .load (wrap),
    .word (cap_word),
    .bits (ser_bits)
  );

  always_ff @(posedge clk_ser or negedge rst_n) begin
    if (!rst_n)                en_q <= 1'b0;
    else if (!pwr_dn_n)        en_q <= 1'b0;
    else if (wrap & cap_valid) en_q <= 1'b1;
  end

  assign drive    = en_q & pwr_dn_n;
  assign lane_oe  = {NUM_LANES{drive}};
  assign lane_bit = ser_bits & {NUM_LANES{drive}};
  assign fclk_oe  = drive;
  assign fclk_bit = fclk_level(slot) & drive;

  p_enable_needs_word_r7: assert property (@(posedge clk_ser) disable iff (!rst_n)
    $rose(en_q) |-> $past(wrap && cap_valid)) else $error("enable without word");
  p_pd_disables_r6: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !pwr_dn_n |=> !en_q) else $error("enable survived power-down");
  p_fclk_frame_r4: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (wrap && drive && pwr_dn_n) |=> (fclk_bit || !pwr_dn_n)) else $error("clock lane low at slot 0");
endmodule

// File: tb/test_tx7_link.sv
module test_tx7_link;
  localparam int NL = 4;
  localparam int DW = NL * 7;
  localparam int NN = 3;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_clk = 1'b0;
  logic edge_sel = 1'b1;
  logic pwr_dn_n = 1'b1;
  logic [DW-1:0] pix_data = '0;
  logic [NL-1:0] lane_bit, lane_oe;
  logic fclk_bit, fclk_oe;
  logic [NN-1:0] n_bit, n_oe;
  logic n_fbit, n_foe;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tx7_link #(.NUM_LANES(NL)) i_tx7_link (
    .clk_ser(clk), .rst_n(rst_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
    .pwr_dn_n(pwr_dn_n), .pix_data(pix_data), .lane_bit(lane_bit),
    .lane_oe(lane_oe), .fclk_bit(fclk_bit), .fclk_oe(fclk_oe));

  tx7_link #(.NUM_LANES(NN)) i_tx7_link_n3 (
    .clk_ser(clk), .rst_n(rst_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
    .pwr_dn_n(pwr_dn_n), .pix_data(pix_data[NN*7-1:0]), .lane_bit(n_bit),
    .lane_oe(n_oe), .fclk_bit(n_fbit), .fclk_oe(n_foe));

  // {edge_sel, word shown in first half of period, word shown in second half}
  localparam logic [2*DW:0] VEC [NV] = '{
    {1'b1, 28'h0000001, 28'hFFFFFFE},
    {1'b0, 28'h0000001, 28'h8000000},
    {1'b1, 28'hAAAAAAA, 28'h5555555},
    {1'b0, 28'hAAAAAAA, 28'h5555555},
    {1'b1, 28'hFFFFFFF, 28'h0000000},
    {1'b0, 28'h0F0F0F0, 28'h8102040},
    {1'b1, 28'h123ABCD, 28'h0000000},
    {1'b0, 28'hFFFFFFF, 28'h0000000}
  };

  function automatic logic [DW-1:0] picked(input logic [2*DW:0] v);
    return v[2*DW] ? v[2*DW-1:DW] : v[DW-1:0];
  endfunction

  function automatic logic [NL-1:0] want_lanes(input logic [DW-1:0] w, input int s);
    logic [NL-1:0] r;
    for (int k = 0; k < NL; k++) r[k] = w[k*7 + s];
    return r;
  endfunction

  function automatic logic [NN-1:0] want_narrow(input logic [DW-1:0] w, input int s);
    logic [NN-1:0] r;
    for (int k = 0; k < NN; k++) r[k] = w[k*7 + s];
    return r;
  endfunction

  function automatic logic want_fclk(input int s);
    return (s < 2) || (s > 4);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one pixel period; entered and left at a falling clock edge with slot 0 current
  task automatic run_period(input logic sel, input logic [DW-1:0] a, input logic [DW-1:0] b,
                            input logic [6:0] pmask, input logic en_exp,
                            input logic [DW-1:0] exp_w, input string tag);
    for (int s = 0; s < 7; s++) begin
      logic on;
      pwr_dn_n = pmask[s];
      edge_sel = sel;
      pix_clk  = (s < 4);
      pix_data = (s < 4) ? a : b;
      #1;
      on = en_exp & pmask[s];
      chk(pmask[s] ? "R7 enable" : "R6 enable", {lane_oe, fclk_oe}, {{NL{on}}, on});
      chk("R5 narrow enable", {n_oe, n_foe}, {{NN{on}}, on});
      if (on) begin
        chk(tag, lane_bit, want_lanes(exp_w, s));
        chk("R4 clock lane", fclk_bit, want_fclk(s));
        chk("R5 narrow lanes", {n_bit, n_fbit}, {want_narrow(exp_w, s), want_fclk(s)});
      end else begin
        chk(pmask[s] ? "R7 quiet" : "R6 quiet", {lane_bit, fclk_bit, n_bit, n_fbit}, '0);
      end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    // R8: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R8 reset enables", {lane_oe, fclk_oe, n_oe, n_foe}, '0);
      chk("R8 reset outputs", {lane_bit, fclk_bit, n_bit, n_fbit}, '0);
    end
    rst_n = 1'b1;
    // first period after reset: enables still off (R7, R8)
    run_period(VEC[0][2*DW], VEC[0][2*DW-1:DW], VEC[0][DW-1:0], 7'h7F, 1'b0, '0, "R8 first period");
    // table walk: each period sends the word picked in the previous one (R1 R2 R3)
    for (int i = 1; i < NV; i++)
      run_period(VEC[i][2*DW], VEC[i][2*DW-1:DW], VEC[i][DW-1:0], 7'h7F, 1'b1,
                 picked(VEC[i-1]), "R1 R2 R3 lanes");
    // power-down falls in slot 3 (R6)
    run_period(1'b1, 28'h3C3C3C3, 28'h3C3C3C3, 7'b0000111, 1'b1, picked(VEC[NV-1]), "R2 lanes");
    // full period powered down with a word that must never appear (R9)
    run_period(1'b0, 28'hDEADBEE, 28'hDEADBEE, 7'b0000000, 1'b0, '0, "R6 idle");
    // released in slot 5; no capture yet, so enables stay off (R7)
    run_period(1'b1, 28'hDEADBEE, 28'hDEADBEE, 7'b1100000, 1'b0, '0, "R7 late release");
    run_period(1'b1, 28'h1234567, 28'h7654321, 7'h7F, 1'b0, '0, "R7 capture period");
    // first word after release is the rising-edge word of the previous period (R9)
    run_period(1'b0, 28'h0ABCDEF, 28'h0FEDCBA, 7'h7F, 1'b1, 28'h1234567, "R9 first word");
    // falling edge picks the second-half word (R1)
    run_period(1'b1, 28'h5A5A5A5, 28'h5A5A5A5, 7'h7F, 1'b1, 28'h0FEDCBA, "R1 falling edge");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule